// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Internal Self-Test Path

This block is one channel of an asynchronous serial port. It has a transmitter that serializes a byte from a one-entry holding register, and a receiver that rebuilds characters from the incoming line. A shared line-control setting picks the character shape: 5 to 8 data bits sent least significant bit first, five parity choices, and one or two stop bits. Both directions are timed by `baud_tick`, which an outside divider pulses for one clock at sixteen times the bit rate. Each serial bit lasts sixteen ticks.

The host writes a byte with `wr_en`. It reads the last received character from `rd_data` and acknowledges it with a one-cycle `rd_en`. The host watches three status flags: received data ready, holding register empty and transmitter fully idle. It also watches two error flags, one for a parity mismatch and one for a low stop bit. Three enable bits select which conditions drive the single interrupt output. A flow-control request bit goes out on a pin, and a clear-to-send pin comes back as a status bit.

For self-test, `loopback` closes the path inside the block. The transmit shift output feeds the receiver, and the serial output pin stays at idle high. The serial input pin is disregarded. The request bit is routed straight into the clear-to-send status, the external clear-to-send pin is ignored, and the request pin is held deasserted. The status flags and the interrupt behave as in normal operation.

Top module: `uart_lb_xcvr`

## Requirements
- R1: A transmitted frame is one low start bit, then the data bits LSB first (`word_len` 0,1,2,3 selects 5,6,7,8 bits), then the optional parity bit, then one stop bit (`stop_two`=0) or two stop bits (`stop_two`=1). Stop bits are high, each bit lasts 16 baud ticks, and the idle line is high.
- R2: `parity_mode` sets the parity bit. 1 makes the total count of ones across data and parity odd. 2 makes that count even. 3 sends a constant 1 and 4 sends a constant 0. The values 0, 5, 6 and 7 send no parity bit.
- R3: A correctly formed incoming frame sets `data_ready`, and `rd_data` presents the received bits zero-extended to 8 bits.
- R4: A low pulse on the receive line that is high again at the middle of the start bit is discarded. No character is produced.
- R5: `parity_err` is set together with `data_ready` when the received parity bit disagrees with the configured mode, and is clear otherwise.
- R6: `framing_err` is set together with `data_ready` when the first stop bit is sampled low, and is clear otherwise.
- R7: A one-cycle `rd_en` clears `data_ready`, `parity_err` and `framing_err` on the next clock.
- R8: `thr_empty` drops on the clock after a write and returns once the byte moves into the shifter. `tx_empty` is high only while the holding register is empty and no frame is being shifted.
- R9: While `loopback` is high, a written byte is received internally, `sout` stays at 1, and `sin` has no effect.
- R10: With `loopback` low, `rts_out` follows `rts_bit` and `cts_status` follows `cts_in`. With `loopback` high, `rts_out` is 0, `cts_status` follows `rts_bit`, and `cts_in` is disregarded.
- R11: `irq` is high exactly when (`ie_rx` and `data_ready`) or (`ie_thre` and `thr_empty`) or (`ie_line` and either error flag), in normal and in loopback mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| word_len | input | 2 | Data bits minus 5 |
| parity_mode | input | 3 | Parity selection (see R2) |
| stop_two | input | 1 | Two stop bits when high |
| loopback | input | 1 | Internal self-test path enable |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Acknowledge of the received character |
| rd_data | output | 8 | Received character |
| data_ready | output | 1 | Received character waiting |
| parity_err | output | 1 | Parity mismatch on the waiting character |
| framing_err | output | 1 | Low stop bit on the waiting character |
| thr_empty | output | 1 | Transmit holding register empty |
| tx_empty | output | 1 | Holding register and shifter both idle |
| ie_rx | input | 1 | Interrupt enable for received data |
| ie_thre | input | 1 | Interrupt enable for holding register empty |
| ie_line | input | 1 | Interrupt enable for line errors |
| irq | output | 1 | Interrupt request |
| rts_bit | input | 1 | Request-to-send control bit |
| rts_out | output | 1 | Request-to-send pin, active high |
| cts_in | input | 1 | Clear-to-send pin, active high |
| cts_status | output | 1 | Clear-to-send status bit |
| sin | input | 1 | Serial receive line |
| sout | output | 1 | Serial transmit line |

## Verification
Transmit frames are decoded from `sout` at mid-bit for five shapes. The shapes cover every word length, every parity mode and both stop lengths, so a shifted data bit, an inverted parity polarity or a missing stop bit each shows up as a different wrong vector. The same frames return through an external wire to the receiver. Further frames are driven directly onto `sin` with a corrupted parity bit, with a low stop bit, and as a short low glitch. These separate the parity check, the framing check and start-bit validation from one another. A loopback run holds `sin` low and toggles `cts_in`, so any leak of a pin into the internal path shows up at the ports.

// File: rtl/uart_lb_xcvr.sv
module uart_lb_xcvr #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] word_len,
  input  logic [2:0] parity_mode,
  input  logic       stop_two,
  input  logic       loopback,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       parity_err,
  output logic       framing_err,
  output logic       thr_empty,
  output logic       tx_empty,
  input  logic       ie_rx,
  input  logic       ie_thre,
  input  logic       ie_line,
  output logic       irq,
  input  logic       rts_bit,
  output logic       rts_out,
  input  logic       cts_in,
  output logic       cts_status,
  input  logic       sin,
  output logic       sout
);
  localparam int TCW = $clog2(OSR);
  localparam logic [TCW-1:0] TC_LAST = TCW'(OSR - 1);
  localparam logic [TCW-1:0] TC_HALF = TCW'(OSR / 2 - 1);
  localparam int FW = 12;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_t;

  function automatic logic par_of(input logic [7:0] d, input logic [2:0] m);
    case (m)
      3'd1:    return ~^d;
      3'd2:    return ^d;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic [2:0] nb_m1;
  logic       par_en;
  logic [7:0] dmask;
  assign nb_m1  = {1'b1, word_len};
  assign par_en = parity_mode inside {3'd1, 3'd2, 3'd3, 3'd4};
  assign dmask  = 8'hFF >> (2'd3 - word_len);

  // transmitter
  logic [7:0]     thr;
  logic           thr_full, tx_busy;
  logic [FW-1:0]  tx_sr, tx_frame;
  logic [3:0]     tx_left, tx_len;
  logic [TCW-1:0] tx_tc;
  logic           tx_line;

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (3'(i) <= nb_m1) tx_frame[1+i] = thr[i];
    if (par_en) tx_frame[4'(nb_m1) + 4'd2] = par_of(thr & dmask, parity_mode);
  end

  assign tx_len  = 4'(nb_m1) + 4'd3 + {3'b0, par_en} + {3'b0, stop_two};
  assign tx_line = tx_busy ? tx_sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      tx_busy  <= 1'b0;
      tx_sr    <= '1;
      tx_left  <= '0;
      tx_tc    <= '0;
    end else begin
      if (!tx_busy && thr_full) begin
        tx_busy <= 1'b1;
        tx_sr   <= tx_frame;
        tx_left <= tx_len;
        tx_tc   <= '0;
      end else if (tx_busy && baud_tick) begin
        if (tx_tc == TC_LAST) begin
          tx_tc   <= '0;
          tx_sr   <= {1'b1, tx_sr[FW-1:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end else begin
          tx_tc <= tx_tc + 1'b1;
        end
      end
      if (wr_en) begin
        thr      <= wr_data;
        thr_full <= 1'b1;
      end else if (!tx_busy && thr_full) begin
        thr_full <= 1'b0;
      end
    end
  end

  assign thr_empty = ~thr_full;
  assign tx_empty  = ~thr_full & ~tx_busy;

  a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && tx_left == 4'd1 |-> tx_sr[0]);
  a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty);

  // receiver
  rx_st_t         rx_st;
  logic           rx_s1, rx_s2, rx_armed, rx_pbit;
  logic [TCW-1:0] rx_tc;
  logic [2:0]     rx_idx;
  logic [7:0]     rx_sh, rbr;
  logic           pe_q, fe_q, dr_q;
  logic           rx_src;

  assign rx_src = loopback ? tx_line : sin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1    <= 1'b1;
      rx_s2    <= 1'b1;
      rx_st    <= RX_IDLE;
      rx_armed <= 1'b0;
      rx_pbit  <= 1'b0;
      rx_tc    <= '0;
      rx_idx   <= '0;
      rx_sh    <= '0;
      rbr      <= '0;
      dr_q     <= 1'b0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
    end else begin
      rx_s1 <= rx_src;
      rx_s2 <= rx_s1;
      if (rd_en) begin
        dr_q <= 1'b0;
        pe_q <= 1'b0;
        fe_q <= 1'b0;
      end
      if (baud_tick) begin
        case (rx_st)
          RX_IDLE: begin
            if (rx_s2) rx_armed <= 1'b1;
            else if (rx_armed) begin
              rx_st    <= RX_START;
              rx_tc    <= '0;
              rx_armed <= 1'b0;
            end
          end
          RX_START: begin
            if (rx_tc == TC_HALF) begin
              rx_tc <= '0;
              if (!rx_s2) begin
                rx_st  <= RX_DATA;
                rx_idx <= '0;
                rx_sh  <= '0;
              end else begin
                rx_st <= RX_IDLE;
              end
            end else rx_tc <= rx_tc + 1'b1;
          end
          RX_DATA: begin
            if (rx_tc == TC_LAST) begin
              rx_tc         <= '0;
              rx_sh[rx_idx] <= rx_s2;
              if (rx_idx == nb_m1) rx_st <= par_en ? RX_PAR : RX_STOP;
              else rx_idx <= rx_idx + 1'b1;
            end else rx_tc <= rx_tc + 1'b1;
          end
          RX_PAR: begin
            if (rx_tc == TC_LAST) begin
              rx_tc   <= '0;
              rx_pbit <= rx_s2;
              rx_st   <= RX_STOP;
            end else rx_tc <= rx_tc + 1'b1;
          end
          default: begin
            if (rx_tc == TC_LAST) begin
              rx_tc <= '0;
              rbr   <= rx_sh;
              dr_q  <= 1'b1;
              pe_q  <= par_en && (rx_pbit != par_of(rx_sh, parity_mode));
              fe_q  <= ~rx_s2;
              rx_st <= RX_IDLE;
            end else rx_tc <= rx_tc + 1'b1;
          end
        endcase
      end
    end
  end

  assign rd_data     = rbr;
  assign data_ready  = dr_q;
  assign parity_err  = pe_q;
  assign framing_err = fe_q;

  a_r4_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
    rx_st == RX_START && baud_tick && rx_tc == TC_HALF && rx_s2 |=> rx_st == RX_IDLE);
  a_r3_ready_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_st == RX_STOP && baud_tick && rx_tc == TC_LAST |=> data_ready);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(rd_en));

  // modem lines, line output, interrupt
  assign sout       = loopback ? 1'b1 : tx_line;
  assign rts_out    = rts_bit & ~loopback;
  assign cts_status = loopback ? rts_bit : cts_in;
  assign irq        = (ie_rx & dr_q) | (ie_thre & thr_empty) | (ie_line & (pe_q | fe_q));
endmodule

// File: tb/test_uart_lb_xcvr.sv
module test_uart_lb_xcvr;
  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic [1:0] word_len = 2'd3;
  logic [2:0] parity_mode = 3'd0;
  logic stop_two = 0, loopback = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic data_ready, parity_err, framing_err, thr_empty, tx_empty, irq;
  logic ie_rx = 0, ie_thre = 0, ie_line = 0;
  logic rts_bit = 0, rts_out, cts_in = 0, cts_status;
  logic sin, sout, sin_drv = 1, ext_loop = 0, mon_on = 0;
  int errs = 0, checks = 0;

  assign sin = ext_loop ? sout : sin_drv;

  always #2 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  uart_lb_xcvr i_uart_lb_xcvr (
    .clk, .rst_n, .baud_tick, .word_len, .parity_mode, .stop_two, .loopback,
    .wr_en, .wr_data, .rd_en, .rd_data, .data_ready, .parity_err, .framing_err,
    .thr_empty, .tx_empty, .ie_rx, .ie_thre, .ie_line, .irq,
    .rts_bit, .rts_out, .cts_in, .cts_status, .sin, .sout);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // per-clock reference for pins, modem routing and interrupt
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      logic e_irq;
      if (loopback) begin
        chk(sout === 1'b1, "R9 sout idle in loopback", sout, 1);
        chk(rts_out === 1'b0, "R10 rts pin inactive", rts_out, 0);
        chk(cts_status === rts_bit, "R10 cts from rts bit", cts_status, rts_bit);
      end else begin
        chk(rts_out === rts_bit, "R10 rts pin", rts_out, rts_bit);
        chk(cts_status === cts_in, "R10 cts pin", cts_status, cts_in);
      end
      e_irq = 0;
      if (ie_rx && data_ready) e_irq = 1;
      if (ie_thre && thr_empty) e_irq = 1;
      if (ie_line && (parity_err || framing_err)) e_irq = 1;
      chk(irq === e_irq, "R11 irq", irq, e_irq);
    end
  end

  function automatic logic [11:0] frame_of(input logic [7:0] d, input int wl,
                                           input int pm, input bit s2, output int len);
    logic [11:0] f;
    int n, ones;
    n = 5 + wl; f = '1; f[0] = 0; ones = 0;
    for (int i = 0; i < n; i++) begin f[1+i] = d[i]; ones += d[i]; end
    len = 1 + n;
    if (pm >= 1 && pm <= 4) begin
      f[len] = (pm == 1) ? (ones % 2 == 0) : (pm == 2) ? (ones % 2 == 1) : (pm == 3);
      len++;
    end
    len += s2 ? 2 : 1;
    return f;
  endfunction

  task automatic set_cfg(input int wl, input int pm, input bit s2);
    word_len = 2'(wl); parity_mode = 3'(pm); stop_two = s2;
  endtask

  task automatic do_read;
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(data_ready == 0 && parity_err == 0 && framing_err == 0, "R7 read clears",
        {data_ready, parity_err, framing_err}, 0);
  endtask

  task automatic wait_tx_idle;
    for (int k = 0; k < 1000 && !tx_empty; k++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic tx_case(input logic [7:0] d, input int wl, input int pm, input bit s2);
    logic [11:0] ef, got;
    int len;
    @(negedge clk);
    set_cfg(wl, pm, s2); ext_loop = 1;
    ef = frame_of(d, wl, pm, s2, len);
    wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    chk(thr_empty == 0, "R8 holding full after write", thr_empty, 0);
    @(negedge clk);
    chk(thr_empty == 1 && tx_empty == 0, "R8 moved to shifter", {thr_empty, tx_empty}, 2);
    got = '1;
    repeat (15) @(negedge clk);
    got[0] = sout;
    for (int b = 1; b < len; b++) begin
      repeat (32) @(negedge clk);
      got[b] = sout;
    end
    chk(got == ef, "R1 R2 frame on sout", got, ef);
    wait_tx_idle;
    chk(data_ready == 1, "R3 echo ready", data_ready, 1);
    chk(rd_data == (d & (8'hFF >> (3 - wl))), "R3 echo data", rd_data, d & (8'hFF >> (3 - wl)));
    chk(parity_err == 0, "R5 no parity error", parity_err, 0);
    chk(framing_err == 0, "R6 no framing error", framing_err, 0);
    do_read;
  endtask

  task automatic rx_case(input logic [7:0] d, input int wl, input int pm, input bit s2,
                         input bit bad_par, input bit bad_stop);
    logic [11:0] f;
    int len;
    @(negedge clk);
    set_cfg(wl, pm, s2); ext_loop = 0;
    f = frame_of(d, wl, pm, s2, len);
    if (bad_par) f[6+wl] = ~f[6+wl];
    if (bad_stop) f[len - (s2 ? 2 : 1)] = 0;
    for (int b = 0; b < len; b++) begin
      sin_drv = f[b];
      repeat (32) @(negedge clk);
    end
    sin_drv = 1;
    repeat (40) @(negedge clk);
    chk(data_ready == 1, "R3 ready", data_ready, 1);
    chk(rd_data == (d & (8'hFF >> (3 - wl))), "R3 data", rd_data, d & (8'hFF >> (3 - wl)));
    chk(parity_err == bad_par, "R5 parity flag", parity_err, bad_par);
    chk(framing_err == bad_stop, "R6 framing flag", framing_err, bad_stop);
    do_read;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_up;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sout == 1 && thr_empty == 1 && tx_empty == 1, "R8 reset status",
        {sout, thr_empty, tx_empty}, 7);
    chk(data_ready == 0 && irq == 0, "R3 reset ready low", {data_ready, irq}, 0);
    mon_on = 1;
    rts_bit = 1; cts_in = 0;
    repeat (3) @(negedge clk);
    cts_in = 1; rts_bit = 0;

    tx_case(8'hA5, 3, 0, 0);
    tx_case(8'h13, 0, 1, 1);
    tx_case(8'h6B, 2, 2, 0);
    tx_case(8'h2C, 1, 3, 0);
    tx_case(8'hF0, 3, 4, 1);
    tx_case(8'h3C, 3, 6, 0);

    ie_line = 1;
    rx_case(8'h96, 3, 2, 0, 0, 0);
    rx_case(8'h4D, 3, 1, 0, 1, 0);
    rx_case(8'h0E, 1, 0, 1, 0, 1);
    rx_case(8'h55, 2, 3, 0, 1, 0);
    ie_line = 0;

    @(negedge clk);
    sin_drv = 0; repeat (6) @(negedge clk); sin_drv = 1;
    repeat (600) @(negedge clk);
    chk(data_ready == 0, "R4 glitch discarded", data_ready, 0);

    // loopback self-test with hostile pins
    set_cfg(3, 2, 0);
    sin_drv = 0; loopback = 1; rts_bit = 1; cts_in = 0; ie_rx = 1;
    @(negedge clk);
    chk(cts_status == 1 && rts_out == 0, "R10 loopback modem", {cts_status, rts_out}, 2);
    wr_en = 1; wr_data = 8'h5A;
    @(negedge clk); wr_en = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); cts_in = ~cts_in; end
    wait_tx_idle;
    chk(data_ready == 1 && rd_data == 8'h5A, "R9 loopback received", rd_data, 8'h5A);
    chk(parity_err == 0 && framing_err == 0, "R9 loopback clean", {parity_err, framing_err}, 0);
    chk(irq == 1, "R11 rx interrupt in loopback", irq, 1);
    do_read;
    chk(irq == 0, "R11 irq drops after read", irq, 0);
    rts_bit = 0; @(negedge clk);
    chk(cts_status == 0, "R10 cts tracks rts bit", cts_status, 0);
    ie_thre = 1; @(negedge clk);
    chk(irq == 1, "R11 holding empty interrupt", irq, 1);
    ie_thre = 0; ie_rx = 0;
    sin_drv = 1; @(negedge clk);
    loopback = 0;
    repeat (600) @(negedge clk);
    chk(data_ready == 0, "R9 no stray character", data_ready, 0);
    finish_up;
  end
endmodule